// File: doc/BRIEF.md
# NAND Flash Write-Operation Pin Sequencer

This block sits between an on-chip requester and a raw NAND flash device. It turns one request into a full write-type bus operation on the device's asynchronous control pins. First it sends a command byte. Then it sends four address bytes. If the request asks for it, a stream of data words follows. Last, the block waits on the shared ready/busy line until the device reports that the operation is finished. Each bus cycle is marked by its own levels on the latch-enable pins. The device takes each cycle on the rising edge of the write strobe. The block times that strobe in clock cycles, using parameters for setup, low time and hold.

The request and the data stream each use a valid/ready handshake. A request moves only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the block is idle, so a second request waits until the first one has finished. A data word moves only when `dat_valid` and `dat_ready` are both high at a clock edge. `dat_ready` rises when the strobe engine is free in the data phase. If `dat_valid` stays low, the block pauses with no further strobe, for as long as the source likes. The word sent with `dat_last` high ends the stream. The outcome is reported as a one-cycle `op_done` pulse or a one-cycle `op_timeout` pulse.

Top module: `nand_wr_seq`

## Requirements
- R1: While idle (also straight after reset), the pins sit at these levels: `nand_ce_n`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0 and `nand_ale`=0. `req_ready` is 1 in this state.
- R2: The first bus cycle of an operation is a command cycle. At its strobe rising edge the pins read `nand_cle`=1, `nand_ale`=0, `nand_ce_n`=0 and `nand_re_n`=1, and `nand_io[7:0]` equals `req_cmd`.
- R3: Exactly four address cycles follow the command. Each has `nand_ale`=1 and `nand_cle`=0 at its rising edge. The bytes go out least significant first: `req_addr[7:0]`, then `[15:8]`, then `[23:16]`, then `[31:24]`.
- R4: Data cycles have both latch enables at 0. `nand_io` carries the handshaken words in order, one strobe per word, and the word with `dat_last` ends the stream. When `req_has_data`=0, no data cycle follows the addresses.
- R5: Each strobe stays low for exactly `T_WLOW` clocks. Between back-to-back cycles it stays high for exactly `T_HOLD`+`T_SETUP` clocks.
- R6: `nand_cle`, `nand_ale` and `nand_io` do not change while the strobe is low. They also stay unchanged for `T_HOLD` clocks after it rises.
- R7: While the data source holds `dat_valid` low, no strobe is issued and `dat_ready` stays high.
- R8: Once a request is accepted, `req_ready` stays low until the operation ends.
- R9: After the last strobe, the block waits out the hold time and then `T_BUSY_DLY` clocks. It then samples ready/busy through a two-flop synchronizer. `op_done` pulses for one clock once the synchronized line reads high, and never while the line is still low.
- R10: If ready/busy stays low for `T_TIMEOUT` clocks of waiting, `op_timeout` pulses for one clock and `op_done` does not pulse.
- R11: In 16-bit mode (`IO_W`=16), command and address cycles drive `nand_io[15:8]` to zero. Data cycles drive the full word.
- R12: After `op_done` or `op_timeout`, the block returns to the idle levels of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken (idle only) |
| req_cmd | input | 8 | Command byte |
| req_addr | input | 32 | Four address bytes, low byte sent first |
| req_has_data | input | 1 | A data stream follows the addresses |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word taken |
| dat_word | input | IO_W | Data word |
| dat_last | input | 1 | Final word of the stream |
| op_done | output | 1 | One-cycle pulse: device reported ready |
| op_timeout | output | 1 | One-cycle pulse: ready never seen |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, held high |
| nand_io | output | IO_W | I/O bus value |
| nand_io_oe | output | 1 | I/O bus drive enable |
| nand_rb | input | 1 | Shared open-drain ready/busy line |

## Verification
The bench sweeps a set of operations. Each one varies the command byte and the address pattern, and uses a data length from zero to four words. Every operation is decoded from the pins at each strobe rising edge. The spread of arithmetic values shows up any byte-order or field error. The zero-length cases separate "no data phase" from "empty data phase". Words spaced apart, and one long stall on the source side, separate back-pressure from normal back-to-back timing, which is where the exact recovery is measured. Three ready/busy shapes are tried: a line that never falls, a short low pulse that ends inside the delay, and a long busy period. A line stuck low is also tried. Between them they separate the delay window, the synchronizer latency and the timeout path.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_DATA} cyc_kind_t;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} we_phase_t;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_DRAIN, ST_DELAY, ST_WAIT
  } seq_state_t;
  localparam int ADDR_BYTES = 4;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], rb_async};
  end

  assign rb_sync = chain[STAGES-1];
endmodule

// File: rtl/nand_we_cycle.sv
module nand_we_cycle
  import nand_seq_pkg::*;
#(
  parameter int IO_W    = 8,
  parameter int T_SETUP = 2,
  parameter int T_WLOW  = 3,
  parameter int T_HOLD  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  cyc_kind_t       kind,
  input  logic [IO_W-1:0] word,
  output logic            busy,
  output logic            last_beat,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic [IO_W-1:0] io,
  output logic            io_oe
);
  localparam int MAXT = (T_SETUP > T_WLOW) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                           : ((T_WLOW > T_HOLD) ? T_WLOW : T_HOLD);
  localparam int CW = $clog2(MAXT + 1);

  we_phase_t       ph;
  logic [CW-1:0]   cnt;
  cyc_kind_t       kind_q;
  logic [IO_W-1:0] word_q;
  logic            setup_end, low_end;

  assign setup_end = (ph == PH_SETUP) && (cnt == CW'(T_SETUP - 1));
  assign low_end   = (ph == PH_LOW)   && (cnt == CW'(T_WLOW - 1));
  assign last_beat = (ph == PH_HOLD)  && (cnt == CW'(T_HOLD - 1));
  assign busy      = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      kind_q <= CYC_CMD;
      word_q <= '0;
    end else begin
      if (start && (!busy || last_beat)) begin
        ph     <= PH_SETUP;
        cnt    <= '0;
        kind_q <= kind;
        // byte-wide cycles keep the upper lines at zero
        word_q <= (kind == CYC_DATA) ? word : IO_W'(word[7:0]);
      end else if (setup_end) begin
        ph  <= PH_LOW;
        cnt <= '0;
      end else if (low_end) begin
        ph  <= PH_HOLD;
        cnt <= '0;
      end else if (last_beat) begin
        ph  <= PH_IDLE;
        cnt <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign we_n  = (ph != PH_LOW);
  assign cle   = busy && (kind_q == CYC_CMD);
  assign ale   = busy && (kind_q == CYC_ADDR);
  assign io    = busy ? word_q : '0;
  assign io_oe = busy;
endmodule

// File: rtl/nand_wr_seq.sv
module nand_wr_seq
  import nand_seq_pkg::*;
#(
  parameter int IO_W       = 8,
  parameter int T_SETUP    = 2,
  parameter int T_WLOW     = 3,
  parameter int T_HOLD     = 2,
  parameter int T_BUSY_DLY = 8,
  parameter int T_TIMEOUT  = 100000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [7:0]      req_cmd,
  input  logic [31:0]     req_addr,
  input  logic            req_has_data,
  input  logic            dat_valid,
  output logic            dat_ready,
  input  logic [IO_W-1:0] dat_word,
  input  logic            dat_last,
  output logic            op_done,
  output logic            op_timeout,
  output logic            nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [IO_W-1:0] nand_io,
  output logic            nand_io_oe,
  input  logic            nand_rb
);
  localparam int WMAX = (T_BUSY_DLY > T_TIMEOUT) ? T_BUSY_DLY : T_TIMEOUT;
  localparam int WCW  = $clog2(WMAX + 1);
  localparam int ACW  = $clog2(ADDR_BYTES);

  seq_state_t      st;
  logic [7:0]      cmd_q;
  logic [31:0]     addr_q;
  logic            has_data_q;
  logic [ACW-1:0]  acnt;
  logic [WCW-1:0]  wcnt;
  logic            rb_s;
  logic            gen_start, gen_busy, gen_last, gen_free;
  cyc_kind_t       gen_kind;
  logic [IO_W-1:0] gen_word;

  nand_rb_sync #(.STAGES(2)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .rb_async(nand_rb), .rb_sync(rb_s)
  );

  nand_we_cycle #(
    .IO_W(IO_W), .T_SETUP(T_SETUP), .T_WLOW(T_WLOW), .T_HOLD(T_HOLD)
  ) u_we_cycle (
    .clk(clk), .rst_n(rst_n), .start(gen_start), .kind(gen_kind),
    .word(gen_word), .busy(gen_busy), .last_beat(gen_last),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .io(nand_io), .io_oe(nand_io_oe)
  );

  assign gen_free = !gen_busy || gen_last;

  always_comb begin
    gen_start = 1'b0;
    gen_kind  = CYC_CMD;
    gen_word  = '0;
    dat_ready = 1'b0;
    unique case (st)
      ST_CMD: begin
        gen_start = gen_free;
        gen_word  = IO_W'(cmd_q);
      end
      ST_ADDR: begin
        gen_start = gen_free;
        gen_kind  = CYC_ADDR;
        gen_word  = IO_W'(addr_q[acnt*8 +: 8]);
      end
      ST_DATA: begin
        dat_ready = gen_free;
        gen_start = gen_free && dat_valid;
        gen_kind  = CYC_DATA;
        gen_word  = dat_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cmd_q      <= '0;
      addr_q     <= '0;
      has_data_q <= 1'b0;
      acnt       <= '0;
      wcnt       <= '0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
    end else begin
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          cmd_q      <= req_cmd;
          addr_q     <= req_addr;
          has_data_q <= req_has_data;
          st         <= ST_CMD;
        end
        ST_CMD: if (gen_start) begin
          acnt <= '0;
          st   <= ST_ADDR;
        end
        ST_ADDR: if (gen_start) begin
          acnt <= acnt + 1'b1;
          if (acnt == ACW'(ADDR_BYTES - 1)) st <= has_data_q ? ST_DATA : ST_DRAIN;
        end
        ST_DATA: if (gen_start && dat_last) st <= ST_DRAIN;
        ST_DRAIN: if (!gen_busy) begin
          wcnt <= '0;
          st   <= ST_DELAY;
        end
        ST_DELAY: begin
          if (wcnt == WCW'(T_BUSY_DLY - 1)) begin
            wcnt <= '0;
            st   <= ST_WAIT;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (rb_s) begin
            op_done <= 1'b1;
            st      <= ST_IDLE;
          end else if (wcnt == WCW'(T_TIMEOUT - 1)) begin
            op_timeout <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign nand_ce_n = (st == ST_IDLE);
  assign nand_re_n = 1'b1;
endmodule

// File: rtl/nand_wr_seq_chk.sv
module nand_wr_seq_chk #(
  parameter int IO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            dat_ready,
  input logic            op_done,
  input logic            op_timeout,
  input logic            nand_ce_n,
  input logic            nand_cle,
  input logic            nand_ale,
  input logic            nand_we_n,
  input logic [IO_W-1:0] nand_io
);
  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_we_n && !nand_cle && !nand_ale));

  // R2
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n);

  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R6
  low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable({nand_cle, nand_ale, nand_io}));

  // R7
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (!nand_ce_n && !req_ready));

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R10
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && op_timeout));

  generate
    if (IO_W > 8) begin : g_wide
      // R11
      upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> (nand_io[IO_W-1:8] == '0));
    end
  endgenerate
endmodule

bind nand_wr_seq nand_wr_seq_chk #(.IO_W(IO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dat_ready(dat_ready), .op_done(op_done), .op_timeout(op_timeout),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_io(nand_io)
);

// File: tb/nand_wr_seq_test.sv
module nand_wr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int IO_W  = 16;
  localparam int T_SU  = 2;
  localparam int T_WL  = 3;
  localparam int T_HD  = 1;
  localparam int T_DLY = 4;
  localparam int T_TO  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_has_data = 1'b0;
  logic [7:0] req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic dat_valid = 1'b0, dat_last = 1'b0;
  logic [IO_W-1:0] dat_word = '0;
  logic nand_rb = 1'b1;
  logic req_ready, dat_ready, op_done, op_timeout;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [IO_W-1:0] nand_io;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_wr_seq #(.IO_W(IO_W), .T_SETUP(T_SU), .T_WLOW(T_WL), .T_HOLD(T_HD),
                .T_BUSY_DLY(T_DLY), .T_TIMEOUT(T_TO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_has_data(req_has_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
    .dat_last(dat_last), .op_done(op_done), .op_timeout(op_timeout),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io(nand_io),
    .nand_io_oe(nand_io_oe), .nand_rb(nand_rb)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // pin monitor: decodes each strobe rising edge
  logic cap_cle [256];
  logic cap_ale [256];
  logic [IO_W-1:0] cap_io [256];
  int ncap = 0;
  int last_rise = 0;
  int done_cnt = 0, tmo_cnt = 0, evt_cyc = 0;
  logic prev_we = 1'b1;
  int low_len = 0, high_len = 0, hold_cnt = 0;
  logic [IO_W+1:0] fl_lines = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (op_done)    begin done_cnt++; evt_cyc = cyc; end
      if (op_timeout) begin tmo_cnt++;  evt_cyc = cyc; end
      if (prev_we && !nand_we_n) begin
        // R5: exact recovery before an address strobe (always back-to-back)
        if (nand_ale)
          chk(high_len == T_HD + T_SU, "R5", "strobe high gap", high_len, T_HD + T_SU);
        fl_lines = {nand_cle, nand_ale, nand_io};
        low_len = 1;
      end else if (!nand_we_n) begin
        low_len++;
        if ({nand_cle, nand_ale, nand_io} != fl_lines)
          chk(0, "R6", "lines moved while strobe low", {nand_cle, nand_ale, nand_io}, fl_lines);
      end
      if (!prev_we && nand_we_n) begin
        chk(low_len == T_WL, "R5", "strobe low width", low_len, T_WL);
        chk(!nand_ce_n && nand_re_n, "R2", "ce_n/re_n at rise", {nand_ce_n, nand_re_n}, 2'b01);
        cap_cle[ncap % 256] = nand_cle;
        cap_ale[ncap % 256] = nand_ale;
        cap_io[ncap % 256]  = nand_io;
        ncap++;
        last_rise = cyc;
        high_len = 1;
        hold_cnt = 1;
      end else if (nand_we_n) begin
        high_len++;
        hold_cnt++;
      end
      if (nand_we_n && hold_cnt >= 1 && hold_cnt <= T_HD &&
          {nand_cle, nand_ale, nand_io} != fl_lines)
        chk(0, "R6", "lines moved in hold", {nand_cle, nand_ale, nand_io}, fl_lines);
      prev_we = nand_we_n;
    end
  end

  task automatic idle_check(input string req);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && req_ready,
        req, "idle levels {ce_n,we_n,re_n,cle,ale,rdy}",
        {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, req_ready}, 6'b111001);
  endtask

  function automatic logic [IO_W-1:0] wval(input int k, input int j);
    return IO_W'((k << 9) ^ (j * 16'h1111) ^ 16'h8001);
  endfunction

  task automatic run_op(input int k, input logic [7:0] cmd, input logic [31:0] addr,
                        input bit has, input int nd, input int gap, input bit stall,
                        input int rb_lo, input bit exp_to);
    int base, nexp, d0, t0, lat, lo, hi, n1;
    base = ncap;
    d0 = done_cnt;
    t0 = tmo_cnt;
    nexp = 5 + (has ? nd : 0);
    @(negedge clk);
    req_cmd = cmd; req_addr = addr; req_has_data = has; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "req_ready after accept", req_ready, 0);
    if (has) begin
      for (int j = 0; j < nd; j++) begin
        dat_word = wval(k, j); dat_last = (j == nd - 1); dat_valid = 1'b1;
        while (!dat_ready) @(negedge clk);
        @(negedge clk);
        dat_valid = 1'b0; dat_last = 1'b0;
        chk(!req_ready, "R8", "req_ready during data", req_ready, 0);
        if (stall && j == 0) begin
          repeat (12) @(negedge clk);
          n1 = ncap;
          chk(dat_ready, "R7", "dat_ready while stalled", dat_ready, 1);
          repeat (8) @(negedge clk);
          chk(ncap == n1, "R7", "strobes during stall", ncap - n1, 0);
        end else begin
          repeat (gap) @(negedge clk);
        end
      end
    end
    for (int w = 0; w < 3000 && ncap < base + nexp; w++) @(negedge clk);
    if (rb_lo > 0) begin
      nand_rb = 1'b0;
      repeat (rb_lo) @(negedge clk);
      nand_rb = 1'b1;
    end
    for (int w = 0; w < 3000 && done_cnt == d0 && tmo_cnt == t0; w++) @(negedge clk);
    chk(ncap - base == nexp, "R4", "strobe count", ncap - base, nexp);
    chk(cap_cle[base % 256] && !cap_ale[base % 256], "R2", "cmd latch levels",
        {cap_cle[base % 256], cap_ale[base % 256]}, 2'b10);
    chk(cap_io[base % 256] == IO_W'(cmd), "R2", "cmd byte", cap_io[base % 256], cmd);
    for (int i = 0; i < 4; i++) begin
      chk(!cap_cle[(base + 1 + i) % 256] && cap_ale[(base + 1 + i) % 256], "R3",
          "addr latch levels", {cap_cle[(base + 1 + i) % 256], cap_ale[(base + 1 + i) % 256]}, 2'b01);
      chk(cap_io[(base + 1 + i) % 256] == IO_W'(addr[i*8 +: 8]), "R3", "addr byte / R11 upper zero",
          cap_io[(base + 1 + i) % 256], addr[i*8 +: 8]);
    end
    if (has)
      for (int j = 0; j < nd; j++) begin
        chk(!cap_cle[(base + 5 + j) % 256] && !cap_ale[(base + 5 + j) % 256], "R4",
            "data latch levels", {cap_cle[(base + 5 + j) % 256], cap_ale[(base + 5 + j) % 256]}, 0);
        chk(cap_io[(base + 5 + j) % 256] == wval(k, j), "R4", "data word / R11 full width",
            cap_io[(base + 5 + j) % 256], wval(k, j));
      end
    lat = evt_cyc - last_rise;
    if (exp_to) begin
      chk(tmo_cnt == t0 + 1 && done_cnt == d0, "R10", "timeout without done",
          {tmo_cnt - t0, done_cnt - d0}, 64'h1_00000000);
      lo = T_HD + T_DLY + T_TO;
      chk(lat >= lo && lat <= lo + 4, "R10", "timeout latency", lat, lo);
    end else begin
      chk(done_cnt == d0 + 1 && tmo_cnt == t0, "R9", "done without timeout",
          {done_cnt - d0, tmo_cnt - t0}, 64'h1_00000000);
      lo = T_HD + T_DLY;
      if (rb_lo + 2 > lo) lo = rb_lo + 2;
      hi = (T_HD + T_DLY > rb_lo) ? T_HD + T_DLY + 6 : rb_lo + 6;
      chk(lat >= lo && lat <= hi, "R9", "done latency", lat, lo);
    end
    @(negedge clk);
    chk(!op_done && !op_timeout, "R9", "outcome pulse width", {op_done, op_timeout}, 0);
    idle_check("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1");
    for (int k = 0; k < 12; k++) begin
      run_op(k, 8'(k * 29 + 5), (32'h01020304 * (k + 1)) ^ 32'hA5C30F96,
             (k % 5) != 0, k % 5, k % 3, 1'b0, (k % 3) * 7, 1'b0);
    end
    // R4: data flag set with a single word; R7 stall
    run_op(20, 8'h80, 32'hFF00FF00, 1'b1, 1, 0, 1'b0, 0, 1'b0);
    run_op(21, 8'h85, 32'h12345678, 1'b1, 2, 0, 1'b1, 2, 1'b0);
    // R9: long busy period
    run_op(22, 8'h60, 32'h00000001, 1'b0, 0, 0, 1'b0, 15, 1'b0);
    // R10: line stuck low past the limit
    run_op(23, 8'hD0, 32'h80000000, 1'b1, 3, 1, 1'b0, 100, 1'b1);
    // R12: block recovers after a timeout
    run_op(24, 8'h10, 32'hCAFEBABE, 1'b1, 2, 0, 1'b0, 0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule